// File: doc/BRIEF.md
# Peer Event Message Decoder

This block takes the byte stream that a coordination server sends to one endpoint of a shared-memory group and turns it into discrete events. Every eight bytes form one signed 64-bit word, least significant byte first. Each word may arrive with a side flag saying that an opaque handle travelled with it. The block never sees the handle itself, only whether it was present. What a word means depends on its value, on that flag and on how far setup has gone. Vector numbers are never carried on the wire. The block infers them by counting the join words it has seen for each peer.

Setup is fixed in order. The first word is a version word. The second is the endpoint's own identity. After that, peer words are handled normally until the word that announces the shared region arrives, which finishes setup. After setup, join and leave words keep updating a fixed-size table of per-peer vector counts. Each decoded event appears as a one-cycle pulse. Each rejected word gives a one-cycle error pulse with a 3-bit cause code, and the block then waits for the next word.

Top module: `pem_decoder`

## Requirements
- R1: While reset is high and in the cycle after it, setup_done, peer_count, own_id and every pulse output are zero.
- R2: A word is complete only on the eighth accepted byte. Bytes are taken only when in_valid is high, with any number of idle cycles between them, and are assembled least significant byte first. in_handle counts only on the eighth byte. The result of a word appears on the pulse outputs in the second cycle after the edge that takes its eighth byte.
- R3: The first word must equal PROTO_VER and carry no handle. Otherwise err_code 2 is pulsed and the block keeps waiting for the version word.
- R4: The second word must carry no handle, must lie in 0..65535, and must be 0 when cfg_master is high. Otherwise err_code 3 is pulsed and the block keeps waiting for the identity. An accepted word sets own_id.
- R5: Any later word below -1 or above 65535, or the value -1 without a handle, pulses err_code 1.
- R6: The value -1 with a handle pulses region_valid and raises setup_done, which then stays high until reset. A second such word pulses err_code 4.
- R7: A value p in 0..65535 with a handle is a join for peer p. The n-th join for p since reset or since p's last leave pulses join_valid with join_peer = p and join_vector = n-1.
- R8: A join for a peer that already holds NUM_VECTORS vectors pulses err_code 5 and leaves that peer's count unchanged.
- R9: A value p in 0..65535 without a handle is a leave. It pulses err_code 6 if p equals own_id. Otherwise it pulses leave_valid with leave_peer = p and resets p's vector count to zero.
- R10: A join or leave naming a peer p at or above peer_count first raises peer_count to p+1, and the new entries hold zero vectors.
- R11: A join or leave naming a peer at or above MAX_PEERS pulses err_code 7 and changes no count.
- R12: A join whose peer equals own_id also pulses local_valid, with local_vector equal to join_vector.
- R13: Every pulse output is high for one cycle per word. An error pulse never coincides with an event pulse, and err_code is nonzero whenever err_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | Endpoint must receive identity 0; held stable outside reset |
| in_valid | input | 1 | A stream byte is present |
| in_byte | input | 8 | Stream byte |
| in_handle | input | 1 | Handle attached to the word completed by this byte |
| setup_done | output | 1 | Region announcement seen |
| own_id | output | 16 | Accepted identity of this endpoint |
| peer_count | output | $clog2(MAX_PEERS+1) | Number of peer entries in use |
| join_valid | output | 1 | Join decoded |
| join_peer | output | 16 | Peer of the join |
| join_vector | output | VEC_W | Vector inferred for the join |
| local_valid | output | 1 | Join for this endpoint, set up a local vector |
| local_vector | output | VEC_W | Local vector to set up |
| leave_valid | output | 1 | Leave decoded |
| leave_peer | output | 16 | Peer that left |
| region_valid | output | 1 | Shared region announced |
| err_valid | output | 1 | Word rejected |
| err_code | output | 3 | Rejection cause, 1..7 as listed in R3 to R11 |

## Verification
Words are sent in several ways: back to back, with idle gaps between bytes, and with the handle flag toggled on the first seven bytes. The last two show that assembly waits for the eighth byte and that only the final flag counts. A peer is joined over and over until the vector limit is hit, then made to leave and joined again, which tells inferred numbering apart from a free-running count. Values just outside the legal range (-2, 65536, -1 without a handle), a peer index just past the table, and an unseen peer that leaves each show a different error code or table growth. A second run with the master setting shows the identity check turning a normally legal identity into an error.

// File: rtl/pem_pkg.sv
package pem_pkg;

    typedef enum logic [2:0] {
        ERR_NONE       = 3'd0,
        ERR_RANGE      = 3'd1,
        ERR_VERSION    = 3'd2,
        ERR_IDENT      = 3'd3,
        ERR_DUP_REGION = 3'd4,
        ERR_VEC_FULL   = 3'd5,
        ERR_SELF_DROP  = 3'd6,
        ERR_TABLE_FULL = 3'd7
    } err_e;

    typedef enum logic [1:0] {
        PH_VERSION,
        PH_IDENT,
        PH_COLLECT,
        PH_LIVE
    } phase_e;

    typedef enum logic [1:0] {
        MK_BAD,
        MK_REGION,
        MK_JOIN,
        MK_LEAVE
    } kind_e;

    typedef struct packed {
        logic [63:0] value;
        logic        handle;
    } word_t;

    // value in 0..65535
    function automatic logic fits_id(input logic [63:0] v);
        return v[63:16] == 48'd0;
    endfunction

    function automatic kind_e classify(input word_t w);
        if (w.value == {64{1'b1}})
            return w.handle ? MK_REGION : MK_BAD;
        else if (!fits_id(w.value))
            return MK_BAD;
        else
            return w.handle ? MK_JOIN : MK_LEAVE;
    endfunction

endpackage

// File: rtl/pem_assembler.sv
module pem_assembler
    import pem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       in_handle,
    output logic       word_valid,
    output word_t      word
);

    logic [2:0]  idx;
    logic [55:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx        <= 3'd0;
            word_valid <= 1'b0;
            acc        <= '0;
            word       <= '0;
        end else begin
            word_valid <= 1'b0;
            if (in_valid) begin
                if (idx == 3'd7) begin
                    word_valid  <= 1'b1;
                    word.value  <= {in_byte, acc};
                    word.handle <= in_handle;
                    idx         <= 3'd0;
                end else begin
                    acc[{idx, 3'b000} +: 8] <= in_byte;
                    idx                     <= idx + 3'd1;
                end
            end
        end
    end

    // R2: a word needs eight bytes, so completions never come back to back
    frame_gap_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);

endmodule

// File: rtl/pem_peer_table.sv
module pem_peer_table #(
    parameter int MAX_PEERS   = 16,
    parameter int NUM_VECTORS = 4,
    localparam int PIDX_W = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
    localparam int CNT_W  = $clog2(NUM_VECTORS + 1),
    localparam int PC_W   = $clog2(MAX_PEERS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_idx,
    input  logic [CNT_W-1:0]  wr_cnt,
    input  logic              grow_en,
    input  logic [PC_W-1:0]   grow_to,
    output logic [PC_W-1:0]   count
);

    logic [CNT_W-1:0] cnt [MAX_PEERS];

    for (genvar g = 0; g < MAX_PEERS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                cnt[g] <= '0;
            else if (wr_en && wr_idx == PIDX_W'(g))
                cnt[g] <= wr_cnt;
        end
    end

    assign rd_cnt = cnt[rd_idx];

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (grow_en)
            count <= grow_to;
    end

    // R10: the table only grows and never exceeds its capacity
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        count <= PC_W'(MAX_PEERS));

    // R10
    grow_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> count >= $past(count));

    // R8: no entry counts past the vector limit
    vec_limit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_cnt <= CNT_W'(NUM_VECTORS) || rd_idx != $past(wr_idx));

endmodule

// File: rtl/pem_decoder.sv
module pem_decoder
    import pem_pkg::*;
#(
    parameter int          MAX_PEERS   = 16,
    parameter int          NUM_VECTORS = 4,
    parameter logic [63:0] PROTO_VER   = 64'd0,
    localparam int PIDX_W = (MAX_PEERS > 1) ? $clog2(MAX_PEERS) : 1,
    localparam int CNT_W  = $clog2(NUM_VECTORS + 1),
    localparam int PC_W   = $clog2(MAX_PEERS + 1),
    localparam int VEC_W  = (NUM_VECTORS > 1) ? $clog2(NUM_VECTORS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_master,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_handle,
    output logic             setup_done,
    output logic [15:0]      own_id,
    output logic [PC_W-1:0]  peer_count,
    output logic             join_valid,
    output logic [15:0]      join_peer,
    output logic [VEC_W-1:0] join_vector,
    output logic             local_valid,
    output logic [VEC_W-1:0] local_vector,
    output logic             leave_valid,
    output logic [15:0]      leave_peer,
    output logic             region_valid,
    output logic             err_valid,
    output logic [2:0]       err_code
);

    logic   w_valid;
    word_t  w;
    phase_e phase, nxt_phase;

    pem_assembler u_asm (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_byte    (in_byte),
        .in_handle  (in_handle),
        .word_valid (w_valid),
        .word       (w)
    );

    logic [15:0]      peer;
    logic [CNT_W-1:0] rd_cnt, t_wr_cnt;
    logic             t_wr_en, t_grow;
    logic [PC_W-1:0]  t_grow_to;

    assign peer = w.value[15:0];

    pem_peer_table #(
        .MAX_PEERS   (MAX_PEERS),
        .NUM_VECTORS (NUM_VECTORS)
    ) u_tab (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (peer[PIDX_W-1:0]),
        .rd_cnt  (rd_cnt),
        .wr_en   (t_wr_en),
        .wr_idx  (peer[PIDX_W-1:0]),
        .wr_cnt  (t_wr_cnt),
        .grow_en (t_grow),
        .grow_to (t_grow_to),
        .count   (peer_count)
    );

    err_e        d_code;
    logic        d_join, d_leave, d_region, d_local;
    logic [15:0] nxt_own;
    kind_e       kind;

    always_comb begin
        kind      = classify(w);
        nxt_phase = phase;
        nxt_own   = own_id;
        d_code    = ERR_NONE;
        d_join    = 1'b0;
        d_leave   = 1'b0;
        d_region  = 1'b0;
        d_local   = 1'b0;
        t_wr_en   = 1'b0;
        t_wr_cnt  = '0;
        t_grow    = 1'b0;
        t_grow_to = peer_count;
        if (w_valid) begin
            unique case (phase)
                PH_VERSION: begin
                    if (!w.handle && w.value == PROTO_VER) nxt_phase = PH_IDENT;
                    else                                   d_code    = ERR_VERSION;
                end
                PH_IDENT: begin
                    if (w.handle || !fits_id(w.value) || (cfg_master && peer != 16'd0))
                        d_code = ERR_IDENT;
                    else begin
                        nxt_own   = peer;
                        nxt_phase = PH_COLLECT;
                    end
                end
                default: begin
                    unique case (kind)
                        MK_BAD: d_code = ERR_RANGE;
                        MK_REGION: begin
                            if (phase == PH_LIVE) d_code = ERR_DUP_REGION;
                            else begin
                                d_region  = 1'b1;
                                nxt_phase = PH_LIVE;
                            end
                        end
                        default: begin
                            if (peer >= 16'(MAX_PEERS)) d_code = ERR_TABLE_FULL;
                            else begin
                                if (peer >= 16'(peer_count)) begin
                                    t_grow    = 1'b1;
                                    t_grow_to = PC_W'(peer) + PC_W'(1);
                                end
                                if (kind == MK_JOIN) begin
                                    if (rd_cnt >= CNT_W'(NUM_VECTORS)) d_code = ERR_VEC_FULL;
                                    else begin
                                        t_wr_en  = 1'b1;
                                        t_wr_cnt = rd_cnt + CNT_W'(1);
                                        d_join   = 1'b1;
                                        d_local  = (peer == own_id);
                                    end
                                end else begin
                                    if (peer == own_id) d_code = ERR_SELF_DROP;
                                    else begin
                                        t_wr_en = 1'b1;
                                        d_leave = 1'b1;
                                    end
                                end
                            end
                        end
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase        <= PH_VERSION;
            own_id       <= '0;
            join_valid   <= 1'b0;
            join_peer    <= '0;
            join_vector  <= '0;
            local_valid  <= 1'b0;
            local_vector <= '0;
            leave_valid  <= 1'b0;
            leave_peer   <= '0;
            region_valid <= 1'b0;
            err_valid    <= 1'b0;
            err_code     <= '0;
        end else begin
            phase        <= nxt_phase;
            own_id       <= nxt_own;
            join_valid   <= d_join;
            join_peer    <= d_join ? peer : 16'd0;
            join_vector  <= d_join ? rd_cnt[VEC_W-1:0] : '0;
            local_valid  <= d_local;
            local_vector <= d_local ? rd_cnt[VEC_W-1:0] : '0;
            leave_valid  <= d_leave;
            leave_peer   <= d_leave ? peer : 16'd0;
            region_valid <= d_region;
            err_valid    <= (d_code != ERR_NONE);
            err_code     <= d_code;
        end
    end

    assign setup_done = (phase == PH_LIVE);

    // R6: once setup completes it stays complete
    setup_hold_chk: assert property (@(posedge clk) disable iff (rst)
        setup_done |=> setup_done);

    // R12: a local strobe always rides on a join for this endpoint
    local_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        local_valid |-> join_valid && join_peer == own_id && local_vector == join_vector);

    // R13: errors exclude every event pulse
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> !join_valid && !leave_valid && !region_valid);

    // R13
    err_code_chk: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> err_code != 3'd0);

    // R9: this endpoint never leaves itself
    self_leave_chk: assert property (@(posedge clk) disable iff (rst)
        leave_valid |-> leave_peer != own_id);

    // R6: a region pulse only comes with setup completing
    region_done_chk: assert property (@(posedge clk) disable iff (rst)
        region_valid |-> setup_done && !$past(setup_done));

endmodule

// File: tb/test_pem_decoder.sv
module test_pem_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_master = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'd0;
    logic        in_handle = 1'b0;
    logic        setup_done;
    logic [15:0] own_id;
    logic [4:0]  peer_count;
    logic        join_valid;
    logic [15:0] join_peer;
    logic [1:0]  join_vector;
    logic        local_valid;
    logic [1:0]  local_vector;
    logic        leave_valid;
    logic [15:0] leave_peer;
    logic        region_valid;
    logic        err_valid;
    logic [2:0]  err_code;

    always #2.5 clk = ~clk;

    pem_decoder i_pem_decoder (
        .clk          (clk),
        .rst          (rst),
        .cfg_master   (cfg_master),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_handle    (in_handle),
        .setup_done   (setup_done),
        .own_id       (own_id),
        .peer_count   (peer_count),
        .join_valid   (join_valid),
        .join_peer    (join_peer),
        .join_vector  (join_vector),
        .local_valid  (local_valid),
        .local_vector (local_vector),
        .leave_valid  (leave_valid),
        .leave_peer   (leave_peer),
        .region_valid (region_valid),
        .err_valid    (err_valid),
        .err_code     (err_code)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [43:0] obs;
        string       tag;
    } exp_t;
    exp_t q[$];

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [43:0] e_err(input logic [2:0] c);
        return {1'b1, c, 40'd0};
    endfunction
    function automatic logic [43:0] e_join(input logic [15:0] p, input logic [1:0] v, input logic loc);
        return {4'd0, 1'b1, p, v, loc, loc ? v : 2'd0, 1'b0, 16'd0, 1'b0};
    endfunction
    function automatic logic [43:0] e_leave(input logic [15:0] p);
        return {4'd0, 1'b0, 16'd0, 2'd0, 1'b0, 2'd0, 1'b1, p, 1'b0};
    endfunction
    function automatic logic [43:0] e_region();
        return {43'd0, 1'b1};
    endfunction

    // monitor: pops one expected item for every cycle with any pulse
    always @(negedge clk) begin
        logic [43:0] o;
        o = {err_valid, err_code, join_valid, join_peer, join_vector,
             local_valid, local_vector, leave_valid, leave_peer, region_valid};
        if (!rst && o != 44'd0) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL R13 unexpected pulse: actual %h expected none", o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (o !== e.obs) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", e.tag, o, e.obs);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    // driver: flag on the first seven bytes is the inverse of the real one
    task automatic send(input logic [63:0] v, input logic h, input int gap,
                        input logic has_exp, input logic [43:0] eo, input string tag);
        if (has_exp) q.push_back('{obs: eo, tag: tag});
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid  = 1'b1;
            in_byte   = v[8*i +: 8];
            in_handle = (i == 7) ? h : ~h;
            if (gap > 0 && i < 7) begin
                @(negedge clk);
                in_valid = 1'b0;
                repeat (gap - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_handle = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        @(negedge clk);
        rst        = 1'b1;
        cfg_master = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    localparam logic [63:0] M1 = {64{1'b1}};

    initial begin
        do_reset(1'b0);
        // R1
        check_eq("R1 setup_done", setup_done, 0);
        check_eq("R1 peer_count", peer_count, 0);
        check_eq("R1 own_id", own_id, 0);
        check_eq("R1 err_valid", err_valid, 0);

        // R3 version stage
        send(64'd1, 1'b0, 0, 1, e_err(3'd2), "R3 wrong version");
        send(64'd0, 1'b1, 0, 1, e_err(3'd2), "R3 version with handle");
        send(64'd0, 1'b0, 0, 0, '0, "");
        check_eq("R3 not yet done", setup_done, 0);

        // R4 identity stage
        send(64'd2, 1'b1, 0, 1, e_err(3'd3), "R4 id with handle");
        send(64'd65536, 1'b0, 0, 1, e_err(3'd3), "R4 id out of range");
        send(64'd2, 1'b0, 0, 0, '0, "");
        check_eq("R4 own_id", own_id, 2);

        // R7 / R10 first join grows table
        send(64'd0, 1'b1, 0, 1, e_join(16'd0, 2'd0, 1'b0), "R7 join peer 0");
        check_eq("R10 count after peer 0", peer_count, 1);

        // R12 / R2 own joins, gapped bytes
        send(64'd2, 1'b1, 2, 1, e_join(16'd2, 2'd0, 1'b1), "R12 own join v0 R2 gaps");
        send(64'd2, 1'b1, 0, 1, e_join(16'd2, 2'd1, 1'b1), "R12 own join v1");
        check_eq("R10 count after peer 2", peer_count, 3);

        // R7 / R8 vector counting to the limit
        send(64'd5, 1'b1, 0, 1, e_join(16'd5, 2'd0, 1'b0), "R7 peer5 v0");
        check_eq("R10 count after peer 5", peer_count, 6);
        send(64'd5, 1'b1, 0, 1, e_join(16'd5, 2'd1, 1'b0), "R7 peer5 v1");
        send(64'd5, 1'b1, 1, 1, e_join(16'd5, 2'd2, 1'b0), "R7 peer5 v2");
        send(64'd5, 1'b1, 0, 1, e_join(16'd5, 2'd3, 1'b0), "R7 peer5 v3");
        send(64'd5, 1'b1, 0, 1, e_err(3'd5), "R8 peer5 full");

        // R5 range errors
        send(64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 0, 1, e_err(3'd1), "R5 minus two");
        send(64'd65536, 1'b1, 0, 1, e_err(3'd1), "R5 above max");
        send(M1, 1'b0, 0, 1, e_err(3'd1), "R5 minus one without handle");

        // R9 leave
        send(64'd2, 1'b0, 0, 1, e_err(3'd6), "R9 own leave");
        send(64'd5, 1'b0, 0, 1, e_leave(16'd5), "R9 leave peer5");
        send(64'd5, 1'b1, 0, 1, e_join(16'd5, 2'd0, 1'b0), "R9 rejoin restarts at v0");

        // R11 overflow
        send(64'd16, 1'b1, 0, 1, e_err(3'd7), "R11 join beyond table");
        send(64'd40000, 1'b0, 0, 1, e_err(3'd7), "R11 leave beyond table");
        check_eq("R11 count unchanged", peer_count, 6);

        // R10 leave of unseen peer grows table
        send(64'd9, 1'b0, 0, 1, e_leave(16'd9), "R10 leave unseen peer");
        check_eq("R10 count after peer 9", peer_count, 10);

        // R6 region
        check_eq("R6 before region", setup_done, 0);
        send(M1, 1'b1, 0, 1, e_region(), "R6 region");
        check_eq("R6 setup_done", setup_done, 1);
        send(M1, 1'b1, 0, 1, e_err(3'd4), "R6 duplicate region");
        send(64'd3, 1'b1, 0, 1, e_join(16'd3, 2'd0, 1'b0), "R7 join after setup");
        check_eq("R6 still done", setup_done, 1);

        // R4 master endpoint
        do_reset(1'b1);
        check_eq("R1 count after second reset", peer_count, 0);
        check_eq("R1 done after second reset", setup_done, 0);
        send(64'd0, 1'b0, 0, 0, '0, "");
        send(64'd3, 1'b0, 0, 1, e_err(3'd3), "R4 master with nonzero id");
        send(64'd0, 1'b0, 0, 0, '0, "");
        send(64'd0, 1'b1, 0, 1, e_join(16'd0, 2'd0, 1'b1), "R4 master id 0 accepted R12");

        repeat (4) @(negedge clk);
        check_eq("R13 no missing pulses", q.size(), 0);
        finish_run();
    end

endmodule